// File: doc/BRIEF.md
# Four-Phase Handshake Clock-Domain Bridge

This block carries one event, together with a data word, from a producer running on one clock to a consumer running on a second clock with no fixed relation to the first. A shared single-cycle strobe cannot work across such a boundary, so the two sides use a return-to-zero request/acknowledge exchange. The sender latches the word, raises its request and keeps the word steady. The receiver sees the request through a three-flop synchronizer, captures the word on the one-cycle edge pulse, raises its acknowledge and emits a one-cycle valid pulse. The sender then drops the request, and the receiver drops the acknowledge when it sees the request low.

The producer asserts `send_start` with a word whenever `send_busy` is low. A start seen while the bridge is busy is dropped. `send_busy` stays high from the launch until the sender has seen the acknowledge return low, so a new transfer can never overlap the tail of the previous one. Each control line that crosses between the domains goes through three flops with an asynchronous active-high reset. The edge pulse is formed from the second and third stages. The two state machines use a synchronous active-high reset.

Top module: `hs_bridge`

## Requirements
- R1: While both resets are held, and right after they are released, send_busy, link_req, link_ack and recv_valid are 0 and recv_data is 0.
- R2: A send_start sampled high at a source clock edge while send_busy is low launches a transfer. From that edge on, link_req and send_busy are both 1.
- R3: The pair {link_req, link_ack} only ever steps through 00, 10, 11, 01 and back to 00. No other change between two observations is allowed.
- R4: link_ack rises only in the cycle after the synchronized request edge pulse. It falls only after the synchronized request has been seen low. link_req falls only after the synchronized acknowledge has been seen high.
- R5: Every launched word appears exactly once on recv_data, in launch order and with the value given at launch. recv_valid is high for the one destination cycle in which recv_data holds the new word.
- R6: A send_start given while send_busy is high has no effect. No extra word is delivered, and link_req does not rise again.
- R7: send_busy falls only once the synchronized acknowledge has been seen low. At that point link_req is 0, and a start in the very next cycle is accepted.
- R8: The word on the crossing stays stable while send_busy is high, even if send_data changes.
- R9: recv_valid is never high on two consecutive destination cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_clk | input | 1 | Producer clock |
| src_rst | input | 1 | Producer reset, active high |
| send_start | input | 1 | Request to launch a transfer |
| send_data | input | DATA_W | Word latched at launch |
| send_busy | output | 1 | A transfer is in flight |
| dst_clk | input | 1 | Consumer clock |
| dst_rst | input | 1 | Consumer reset, active high |
| recv_valid | output | 1 | One-cycle pulse: a new word is on recv_data |
| recv_data | output | DATA_W | Last word received |
| link_req | output | 1 | Request line (source domain) |
| link_ack | output | 1 | Acknowledge line (destination domain) |

## Verification
The bench issues a start while a transfer is in flight and changes send_data mid-transfer. A bridge that accepts starts while busy would deliver a spurious word. One that reads the live input would deliver a corrupted word. Back-to-back launches fired on the first idle cycle show whether busy drops too early; an early drop would overlap phases and break the 00-10-11-01 walk watched on both clocks. The consumer side is checked for duplicate or merged valid pulses, which a wrong edge-tap choice in the synchronizer would produce, and for lost or reordered words.

// File: rtl/hs_bridge_pkg.sv
package hs_bridge_pkg;

    // Source-side sequencing
    typedef enum logic [1:0] {
        TX_IDLE,          // no transfer, request low
        TX_WAIT_ACK,      // request high, waiting for acknowledge edge
        TX_WAIT_RELEASE   // request low, waiting for acknowledge to drop
    } tx_state_e;

    // Destination-side sequencing
    typedef enum logic {
        RX_IDLE,          // acknowledge low
        RX_HOLD           // acknowledge high, waiting for request to drop
    } rx_state_e;

    localparam int unsigned MIN_SYNC_STAGES = 3;

endpackage

// File: rtl/hs_sync.sv
module hs_sync #(
    parameter int unsigned STAGES = 3
) (
    input  logic clk,
    input  logic arst,
    input  logic async_in,
    output logic level,
    output logic rise
);
    import hs_bridge_pkg::*;

    generate
        if (STAGES < MIN_SYNC_STAGES) begin : g_bad_depth
            $error("hs_sync needs at least three stages");
        end
    endgenerate

    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or posedge arst) begin
        if (arst) chain <= '0;
        else      chain <= {chain[STAGES-2:0], async_in};
    end

    // edge taken from the last two stages
    assign level = chain[STAGES-2];
    assign rise  = chain[STAGES-2] & ~chain[STAGES-1];

    a_r9_rise_single: assert property (@(posedge clk) disable iff (arst)
        rise |=> !rise);

endmodule

// File: rtl/hs_sender.sv
module hs_sender
    import hs_bridge_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [DATA_W-1:0] din,
    input  logic              ack_rise,
    input  logic              ack_level,
    output logic              req,
    output logic [DATA_W-1:0] word,
    output logic              busy
);
    tx_state_e         state;
    logic [DATA_W-1:0] word_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= TX_IDLE;
            req    <= 1'b0;
            word_q <= '0;
        end else begin
            unique case (state)
                TX_IDLE: if (start) begin
                    word_q <= din;
                    req    <= 1'b1;
                    state  <= TX_WAIT_ACK;
                end
                TX_WAIT_ACK: if (ack_rise) begin
                    req   <= 1'b0;
                    state <= TX_WAIT_RELEASE;
                end
                TX_WAIT_RELEASE: if (!ack_level) begin
                    state <= TX_IDLE;
                end
                default: state <= TX_IDLE;
            endcase
        end
    end

    assign busy = (state != TX_IDLE);
    assign word = word_q;

    a_r8_word_held: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(word_q));
    a_r6_no_relaunch: assert property (@(posedge clk) disable iff (rst)
        busy |=> !$rose(req));
    a_r4_req_drop_after_ack: assert property (@(posedge clk) disable iff (rst)
        $fell(req) |-> $past(ack_level));
    a_r7_busy_until_ack_low: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (!$past(ack_level) && !req));

endmodule

// File: rtl/hs_receiver.sv
module hs_receiver
    import hs_bridge_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_rise,
    input  logic              req_level,
    input  logic [DATA_W-1:0] din,
    output logic              ack,
    output logic              valid,
    output logic [DATA_W-1:0] dout
);
    rx_state_e state;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= RX_IDLE;
            ack   <= 1'b0;
            valid <= 1'b0;
            dout  <= '0;
        end else begin
            valid <= 1'b0;
            unique case (state)
                RX_IDLE: if (req_rise) begin
                    dout  <= din;
                    valid <= 1'b1;
                    ack   <= 1'b1;
                    state <= RX_HOLD;
                end
                RX_HOLD: if (!req_level) begin
                    ack   <= 1'b0;
                    state <= RX_IDLE;
                end
                default: state <= RX_IDLE;
            endcase
        end
    end

    a_r4_ack_rise_on_edge: assert property (@(posedge clk) disable iff (rst)
        $rose(ack) |-> $past(req_rise));
    a_r4_ack_fall_on_low: assert property (@(posedge clk) disable iff (rst)
        $fell(ack) |-> !$past(req_level));
    a_r9_valid_single: assert property (@(posedge clk) disable iff (rst)
        valid |=> !valid);
    a_r5_valid_with_ack: assert property (@(posedge clk) disable iff (rst)
        valid |-> $rose(ack));

endmodule

// File: rtl/hs_bridge.sv
module hs_bridge
    import hs_bridge_pkg::*;
#(
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned SYNC_STAGES = 3
) (
    input  logic              src_clk,
    input  logic              src_rst,
    input  logic              send_start,
    input  logic [DATA_W-1:0] send_data,
    output logic              send_busy,
    input  logic              dst_clk,
    input  logic              dst_rst,
    output logic              recv_valid,
    output logic [DATA_W-1:0] recv_data,
    output logic              link_req,
    output logic              link_ack
);
    logic              req_w, ack_w;
    logic [DATA_W-1:0] word_w;
    logic              ack_lvl_s, ack_rise_s;
    logic              req_lvl_d, req_rise_d;

    hs_sender #(.DATA_W(DATA_W)) u_tx (
        .clk       (src_clk),
        .rst       (src_rst),
        .start     (send_start),
        .din       (send_data),
        .ack_rise  (ack_rise_s),
        .ack_level (ack_lvl_s),
        .req       (req_w),
        .word      (word_w),
        .busy      (send_busy)
    );

    // acknowledge into the source domain
    hs_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
        .clk      (src_clk),
        .arst     (src_rst),
        .async_in (ack_w),
        .level    (ack_lvl_s),
        .rise     (ack_rise_s)
    );

    // request into the destination domain
    hs_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
        .clk      (dst_clk),
        .arst     (dst_rst),
        .async_in (req_w),
        .level    (req_lvl_d),
        .rise     (req_rise_d)
    );

    hs_receiver #(.DATA_W(DATA_W)) u_rx (
        .clk       (dst_clk),
        .rst       (dst_rst),
        .req_rise  (req_rise_d),
        .req_level (req_lvl_d),
        .din       (word_w),
        .ack       (ack_w),
        .valid     (recv_valid),
        .dout      (recv_data)
    );

    assign link_req = req_w;
    assign link_ack = ack_w;

endmodule

// File: tb/hs_bridge_test.sv
module hs_bridge_test;
    localparam int SRC_PERIOD = 10;
    localparam int DST_PERIOD = 14;
    localparam int DW         = 8;

    logic          src_clk = 1'b0, dst_clk = 1'b0;
    logic          src_rst = 1'b1, dst_rst = 1'b1;
    logic          send_start = 1'b0;
    logic [DW-1:0] send_data  = '0;
    logic          send_busy, recv_valid, link_req, link_ack;
    logic [DW-1:0] recv_data;

    int compared = 0, mismatched = 0, sent = 0, delivered = 0;
    logic [DW-1:0] expect_q[$];
    logic          prev_valid = 1'b0, prev_busy = 1'b0;
    logic [1:0]    prev_phase = 2'b00;

    always #(SRC_PERIOD/2) src_clk = ~src_clk;
    always #(DST_PERIOD/2) dst_clk = ~dst_clk;

    hs_bridge #(.DATA_W(DW), .SYNC_STAGES(3)) uut (
        .src_clk(src_clk), .src_rst(src_rst), .send_start(send_start),
        .send_data(send_data), .send_busy(send_busy), .dst_clk(dst_clk),
        .dst_rst(dst_rst), .recv_valid(recv_valid), .recv_data(recv_data),
        .link_req(link_req), .link_ack(link_ack)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic report;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    endtask

    // R2/R6/R8: launch one word; optionally poke start and data while busy
    task automatic send(input logic [DW-1:0] d, input bit poke);
        while (send_busy) @(negedge src_clk);
        send_start = 1'b1;
        send_data  = d;
        @(negedge src_clk);
        expect_q.push_back(d);
        sent++;
        check(link_req === 1'b1 && send_busy === 1'b1, "R2 launch", {link_req, send_busy}, 3);
        send_start = 1'b0;
        if (poke) begin
            // R6: start while busy must be ignored; R8: live data changes
            send_start = 1'b1;
            send_data  = ~d;
            @(negedge src_clk);
            send_start = 1'b0;
            send_data  = d ^ 8'h5A;
            @(negedge src_clk);
            check(send_busy === 1'b1, "R6 busy held", send_busy, 1);
        end
    endtask

    // R3: handshake phase walk, observed on both clocks
    always @(negedge src_clk or negedge dst_clk) begin
        if (!src_rst && !dst_rst) begin
            logic [1:0] ph;
            bit ok;
            ph = {link_req, link_ack};
            ok = (ph == prev_phase) ||
                 (prev_phase == 2'b00 && ph == 2'b10) ||
                 (prev_phase == 2'b10 && ph == 2'b11) ||
                 (prev_phase == 2'b11 && ph == 2'b01) ||
                 (prev_phase == 2'b01 && ph == 2'b00);
            check(ok, "R3 phase order", {prev_phase, ph}, {prev_phase, prev_phase});
            prev_phase = ph;
        end
    end

    // R7: busy falls only with request and acknowledge both low
    always @(negedge src_clk) begin
        if (!src_rst) begin
            if (prev_busy && !send_busy)
                check(link_req === 1'b0 && link_ack === 1'b0, "R7 busy release",
                      {link_req, link_ack}, 0);
            prev_busy = send_busy;
        end
    end

    // R5/R9: consumer side compared every destination clock
    always @(negedge dst_clk) begin
        if (!dst_rst) begin
            check(!(prev_valid && recv_valid), "R9 single pulse", {prev_valid, recv_valid}, 2);
            if (recv_valid) begin
                if (expect_q.size() == 0) begin
                    check(1'b0, "R5 unexpected word", recv_data, 0);
                end else begin
                    logic [DW-1:0] e;
                    e = expect_q.pop_front();
                    check(recv_data === e, "R5 word value", recv_data, e);
                    delivered++;
                end
            end
            prev_valid = recv_valid;
        end
    end

    initial begin
        repeat (50000) @(posedge src_clk);
        mismatched++;
        $display("FAIL watchdog expired actual=0 expected=1");
        report();
    end

    initial begin
        repeat (6) @(negedge dst_clk);
        @(negedge src_clk);
        check({send_busy, link_req, link_ack, recv_valid} === 4'b0 && recv_data === '0,
              "R1 in reset", {send_busy, link_req, link_ack, recv_valid}, 0);
        src_rst = 1'b0;
        dst_rst = 1'b0;
        @(negedge src_clk);
        check({send_busy, link_req, link_ack, recv_valid} === 4'b0 && recv_data === '0,
              "R1 after release", {send_busy, link_req, link_ack, recv_valid}, 0);

        // single transfer with start and data disturbed while busy
        send(8'hA5, 1'b1);
        send(8'h00, 1'b1);
        send(8'hFF, 1'b0);
        // back-to-back: each launch on the first idle cycle (R7)
        send(8'h01, 1'b0);
        send(8'h80, 1'b0);
        for (int i = 0; i < 20; i++) send(DW'(i * 37 + 11), (i % 3) == 0);

        while (send_busy) @(negedge src_clk);
        repeat (12) @(negedge dst_clk);
        check(delivered == sent, "R5 delivered count", delivered, sent);
        check(expect_q.size() == 0, "R6 no extra or missing word", expect_q.size(), 0);
        check(link_req === 1'b0 && link_ack === 1'b0, "R3 idle at end",
              {link_req, link_ack}, 0);
        report();
    end

endmodule